// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit keeps the status byte of a serial flash device and decides whether a write to that byte may proceed. The command decoder presents a one-cycle write request with an 8-bit data value. The unit weighs that request against the level of the external write-protect pin and against a lock-down bit held inside the register. It then answers with a single-cycle accept or reject pulse. The stored byte, and the two-bit block-protect field taken from it, are always visible so that array program and erase gating can use them.

The write-protect pin is asynchronous to the unit clock, so it passes through a synchroniser before it reaches the decision. The lock-down bit and the block-protect bits are the only bits the write path can change. The busy and write-enable-latch positions are owned by other logic and hold their reset value here. Reset leaves the array fully protected and the lock-down bit clear.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset the status byte reads 8'h0C: lock-down bit 7 is 0, block-protect bits 3:2 are 1, all other bits are 0, and neither response pulse is high.
- R2: When the synchronised pin level is high, a request is accepted whatever the value of lock-down bit 7.
- R3: When the synchronised pin level is low and bit 7 is 0, a request is accepted.
- R4: When the synchronised pin level is low and bit 7 is 1, a request is rejected and the status byte keeps its value.
- R5: Every request sampled at a clock edge yields exactly one of wr_ack or wr_nak, high for the one cycle after that edge. No pulse appears without a request.
- R6: An accepted request loads data bits 7, 3 and 2 into the status byte in the cycle after the request. Bits 1:0 (busy, write-enable latch) and bits 6:4 are never changed by a write and read 0.
- R7: bp_field always equals status bits 3:2.
- R8: The pin passes through a two-flop synchroniser. A request sampled at the first or second clock edge after a pin change still sees the old level, and one sampled at the third edge sees the new level.
- R9: A request directly after an accepted write is judged with the lock-down bit that this write stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_req | input | 1 | One-cycle status write request |
| wr_data | input | 8 | Value offered for the status byte |
| wp_n_pin | input | 1 | Raw write-protect pin level, active low, asynchronous |
| sr_q | output | 8 | Current status byte |
| bp_field | output | 2 | Block-protect field for array write gating |
| wr_ack | output | 1 | Request accepted, one-cycle pulse |
| wr_nak | output | 1 | Request refused, one-cycle pulse |

## Verification
On every cycle the assertions check several properties. Accept and reject never appear together, and a response is tied to a request one cycle earlier. A request is answered according to the synchronised pin level and the lock bit. A rejected request leaves the byte untouched, an accepted one loads the writable bits, and the non-writable positions stay zero. The synchroniser latency, the reset value, the match between bp_field and the byte, and the back-to-back case where a write locks out its successor can only be shown by the bench. It does this with timed sequences of pin changes and requests whose expected outcomes it predicts from its own model.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

   typedef enum logic [1:0] {
      RESP_NONE = 2'd0,
      RESP_ACK  = 2'd1,
      RESP_NAK  = 2'd2
   } resp_e;

   // A write is allowed when the pin releases the lock or the lock bit is clear.
   function automatic logic wr_allowed(input logic pin_level,
                                       input logic lock_bit,
                                       input bit   lock_en);
      if (!lock_en) return 1'b1;
      return pin_level | ~lock_bit;
   endfunction

endpackage

// File: rtl/sr_wp_sync.sv
module sr_wp_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sr_wp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sr_wp_gate.sv
module sr_wp_gate
   import sr_wp_pkg::*;
#(
   parameter bit LOCK_EN = 1'b1
) (
   input  logic pin_level,
   input  logic lock_bit,
   output logic allow
);

   if (LOCK_EN) begin : g_locking
      always_comb allow = wr_allowed(pin_level, lock_bit, 1'b1);
   end else begin : g_open
      logic unused_gate;
      assign unused_gate = pin_level ^ lock_bit;
      always_comb allow = 1'b1;
   end

endmodule

// File: rtl/sr_wp_store.sv
module sr_wp_store #(
   parameter int              SR_W    = 8,
   parameter logic [SR_W-1:0] WR_MASK = '0,
   parameter logic [SR_W-1:0] RST_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SR_W-1:0] d,
   output logic [SR_W-1:0] q
);

   logic unused_bits;
   assign unused_bits = ^(d & ~WR_MASK);

   for (genvar b = 0; b < SR_W; b++) begin : g_bit
      if (WR_MASK[b]) begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n)    q[b] <= RST_VAL[b];
            else if (load) q[b] <= d[b];
         end
      end else begin : g_ro
         assign q[b] = RST_VAL[b];
      end
   end

endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
   import sr_wp_pkg::*;
#(
   parameter int SR_W        = 8,
   parameter int LOCK_BIT    = 7,
   parameter int BP_LSB      = 2,
   parameter int BP_W        = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit LOCK_EN     = 1'b1,
   parameter bit PIN_RST     = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_req,
   input  logic [SR_W-1:0] wr_data,
   input  logic            wp_n_pin,
   output logic [SR_W-1:0] sr_q,
   output logic [BP_W-1:0] bp_field,
   output logic            wr_ack,
   output logic            wr_nak
);

   localparam logic [SR_W-1:0] BP_MASK   = SR_W'(((1 << BP_W) - 1) << BP_LSB);
   localparam logic [SR_W-1:0] LOCK_MASK = SR_W'(1) << LOCK_BIT;
   localparam logic [SR_W-1:0] WR_MASK   = BP_MASK | LOCK_MASK;
   localparam logic [SR_W-1:0] RST_VAL   = BP_MASK;

   if (LOCK_BIT >= SR_W) begin : g_bad_lock
      $error("sr_wp_unit: LOCK_BIT outside the register");
   end
   if (BP_LSB + BP_W > SR_W) begin : g_bad_bp
      $error("sr_wp_unit: block-protect field outside the register");
   end
   if (BP_LSB < 2) begin : g_bad_low
      $error("sr_wp_unit: bits 1:0 are reserved for busy and write-enable");
   end
   if (LOCK_BIT >= BP_LSB && LOCK_BIT < BP_LSB + BP_W) begin : g_bad_overlap
      $error("sr_wp_unit: lock bit overlaps block-protect field");
   end

   logic  wp_sync;
   logic  allow;
   logic  load;
   resp_e resp_q;

   sr_wp_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wp_n_pin),
      .q     (wp_sync)
   );

   sr_wp_gate #(
      .LOCK_EN (LOCK_EN)
   ) u_gate (
      .pin_level (wp_sync),
      .lock_bit  (sr_q[LOCK_BIT]),
      .allow     (allow)
   );

   assign load = wr_req & allow;

   sr_wp_store #(
      .SR_W    (SR_W),
      .WR_MASK (WR_MASK),
      .RST_VAL (RST_VAL)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (wr_data),
      .q     (sr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      resp_q <= RESP_NONE;
      else if (!wr_req) resp_q <= RESP_NONE;
      else if (allow)  resp_q <= RESP_ACK;
      else             resp_q <= RESP_NAK;
   end

   assign wr_ack   = (resp_q == RESP_ACK);
   assign wr_nak   = (resp_q == RESP_NAK);
   assign bp_field = sr_q[BP_LSB +: BP_W];

endmodule

// File: rtl/sr_wp_chk.sv
module sr_wp_chk #(
   parameter int              SR_W     = 8,
   parameter int              LOCK_BIT = 7,
   parameter bit              LOCK_EN  = 1'b1,
   parameter logic [SR_W-1:0] WR_MASK  = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_req,
   input logic [SR_W-1:0] wr_data,
   input logic            wp_s,
   input logic [SR_W-1:0] sr_q,
   input logic            wr_ack,
   input logic            wr_nak
);

   AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ack && wr_nak)); // R5

   AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack || wr_nak) |-> $past(wr_req)); // R5

   AST_REQ_GETS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (wr_ack || wr_nak)); // R5

   AST_OPEN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && (wp_s || !sr_q[LOCK_BIT] || !LOCK_EN)) |=> wr_ack); // R2

   AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wp_s && sr_q[LOCK_BIT] && LOCK_EN) |=> wr_nak); // R4

   AST_NAK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_nak |-> $stable(sr_q)); // R4

   AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |-> ((sr_q & WR_MASK) == ($past(wr_data) & WR_MASK))); // R6

   AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_q & ~WR_MASK) == '0); // R6

endmodule

bind sr_wp_unit sr_wp_chk #(
   .SR_W     (SR_W),
   .LOCK_BIT (LOCK_BIT),
   .LOCK_EN  (LOCK_EN),
   .WR_MASK  (WR_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_req  (wr_req),
   .wr_data (wr_data),
   .wp_s    (wp_sync),
   .sr_q    (sr_q),
   .wr_ack  (wr_ack),
   .wr_nak  (wr_nak)
);

// File: tb/tb_sr_wp_unit.sv
module tb_sr_wp_unit;

   typedef struct {
      logic       ack;
      logic       nak;
      logic [7:0] sr;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_req = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wp_n_pin = 1'b1;
   logic [7:0] sr_q;
   logic [1:0] bp_field;
   logic       wr_ack;
   logic       wr_nak;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb[$];
   logic req_prev = 1'b0;

   logic       model_wp = 1'b1;
   logic [7:0] model_sr = 8'h0C;

   always #5 clk = ~clk;

   sr_wp_unit dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .wp_n_pin (wp_n_pin),
      .sr_q     (sr_q),
      .bp_field (bp_field),
      .wr_ack   (wr_ack),
      .wr_nak   (wr_nak)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: called at a negedge, drives one request for the next edge.
   task automatic send(input logic [7:0] d, input string tag);
      exp_t e;
      logic ok;
      ok = model_wp | ~model_sr[7];
      if (ok) model_sr = d & 8'h8C;
      e.ack = ok;
      e.nak = ~ok;
      e.sr  = model_sr;
      e.tag = tag;
      sb.push_back(e);
      wr_req  = 1'b1;
      wr_data = d;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      wr_req = 1'b0;
      wr_data = 8'h00;
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pin(input logic v);
      wp_n_pin = v;
      idle(4);
      model_wp = v;
   endtask

   always @(posedge clk) req_prev <= wr_req;

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (req_prev) begin
            if (sb.size() == 0) begin
               check(1'b0, "R5 response with empty scoreboard", 16'h0, 16'h0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(wr_ack === e.ack && wr_nak === e.nak, {e.tag, " ack/nak"},
                     {14'h0, wr_ack, wr_nak}, {14'h0, e.ack, e.nak});
               check(sr_q === e.sr, {e.tag, " status"}, {8'h0, sr_q}, {8'h0, e.sr});
               check(bp_field === e.sr[3:2], "R7 bp_field", {14'h0, bp_field},
                     {14'h0, e.sr[3:2]});
            end
         end else if (wr_ack || wr_nak) begin
            check(1'b0, "R5 pulse without request", {14'h0, wr_ack, wr_nak}, 16'h0);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(sr_q === 8'h0C, "R1 status after reset", {8'h0, sr_q}, 16'h000C);
      check(!wr_ack && !wr_nak, "R1 no pulse after reset", {14'h0, wr_ack, wr_nak}, 16'h0);
      check(bp_field === 2'b11, "R7 reset bp_field", {14'h0, bp_field}, 16'h0003);

      // R2 and R6: pin high, all ones written, only bits 7,3,2 land
      set_pin(1'b1);
      send(8'hFF, "R2 R6 open write");
      idle(2);

      // R2: pin high with lock set still accepted
      send(8'hC8, "R2 lock ignored by high pin");
      idle(2);

      // R4: pin low with lock set
      set_pin(1'b0);
      send(8'h00, "R4 locked reject");
      idle(2);
      send(8'h7F, "R4 locked reject second");
      idle(2);

      // R8: pin goes high, requests at edges 1 and 2 see old level, 3rd sees new
      wp_n_pin = 1'b1;
      send(8'h04, "R8 edge1 old level");
      send(8'h04, "R8 edge2 old level");
      model_wp = 1'b1;
      send(8'h04, "R8 edge3 new level");
      idle(3);

      // R3 and R9: pin low, lock clear, write sets lock, next write refused
      set_pin(1'b0);
      send(8'h00, "R3 unlocked accept");
      send(8'h88, "R3 R9 sets lock");
      send(8'h00, "R9 back-to-back refused");
      idle(2);

      // R7: pin high, distinct block-protect patterns
      set_pin(1'b1);
      send(8'h08, "R7 bp=10");
      send(8'h04, "R7 bp=01");
      send(8'h00, "R7 bp=00");
      idle(6);

      // R5: idle stretch carries no pulses
      check(!wr_ack && !wr_nak && sb.size() == 0, "R5 idle quiet",
            {14'h0, wr_ack, wr_nak}, 16'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule